// File: doc/BRIEF.md
# Serial In-System Programming Target

This block lets an external host program an on-chip program array and a small data array over a three-wire serial link: a serial clock and a data line from the host, and one data line back. The port listens only while the hold input is driven low. It starts locked, and it unlocks only after a valid enable instruction. Every instruction is four bytes long. The block brings the serial clock and data into the CPU clock domain and checks that each serial clock phase is long enough. It decodes each instruction and drives a byte-wide memory interface, and the memory arrays sit outside the block. After an erase or a write, the port stays busy for a fixed number of CPU cycles.

The controller is a four-state machine:

- **OFF**: hold is high.
- **LOCKED**: hold is low but the port has not been enabled.
- **READY**: the port is enabled and idle.
- **BUSY**: a self-timed erase or write is running.

Transitions:

- **OFF to LOCKED** when the synchronised hold goes low.
- **LOCKED to READY** when an enable instruction ends.
- **READY to BUSY** when an erase or write is issued.
- **BUSY to READY** when the busy counter expires.
- **Any state to OFF** when hold returns high.

Top module: `spi_isp_slave`

## Requirements
- R1: The port acts only while `hold_n` is low. Raising `hold_n` aborts any partial instruction, relocks the port, and forces `miso` to 0 and `busy` to 0.
- R2: Until the port is enabled, no instruction causes a memory operation, and `miso` stays 0 except for the enable echo.
- R3: The instruction `AC 53 xx xx` enables the port, and `53` is returned on `miso` during the third byte. A second byte other than `53` returns 0 in byte three and leaves the port locked.
- R4: Bytes are sent most significant bit first. `mosi` is sampled on rising `sck`, and `miso` changes after falling `sck`.
- R5: The instruction `AC 80 xx xx` issues `mem_op` = 1 (erase all). Afterwards every byte of both arrays reads 0xFF.
- R6: The instruction `C0 ah al dd` writes the data array (`mem_space` = 1) with `mem_op` = 3 (erase then write). The byte then holds `dd` whatever it held before.
- R7: The instruction `40 ah al dd` writes the program array (`mem_space` = 0) with `mem_op` = 2 (program), which can only clear bits.
- R8: The instruction `20 ah al xx` reads the program array and `A0 ah al xx` reads the data array. The addressed byte is returned on `miso` during the fourth byte. The address is `{ah,al}` cut to ADDR_W bits.
- R9: After an erase or write, `busy` is high for exactly BUSY_CYC CPU cycles. The instruction `F0 xx xx xx` returns `busy` in bit 0 of the fourth byte, with the other bits 0.
- R10: While `busy` is high, erase and write instructions are ignored.
- R11: A serial clock high or low phase of at most MIN CPU cycles sets the sticky `sck_err` flag. MIN is 2, or 3 when FAST_CLK is 1. Raising `hold_n` clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| hold_n | input | 1 | Programming hold, port active while low |
| sck | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| sck_err | output | 1 | Sticky flag for a serial clock phase that is too short |
| busy | output | 1 | Self-timed operation in progress |
| mem_op | output | 2 | Memory operation pulse: 0 none, 1 erase all, 2 program, 3 erase-write |
| mem_space | output | 1 | Array select: 0 program, 1 data |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_re | output | 1 | Read strobe; data is expected on `mem_rdata` one cycle later |
| mem_rdata | input | 8 | Read data |

## Verification
The bench builds the block with ADDR_W=5, BUSY_CYC=800 and FAST_CLK=0. With BUSY_CYC=800, the busy window covers more than two full instructions. That lets the bench send an ignored write and then a poll that still reports busy, all inside one erase. The 5-bit address keeps the bench's memory model small while still exercising address truncation. With the lower phase threshold, a two-cycle clock pulse is the longest phase that counts as an error, while the bench's normal five-cycle phases pass.

// File: rtl/isp_pkg.sv
package isp_pkg;

    typedef enum logic [1:0] {
        MOP_NONE      = 2'd0,
        MOP_ERASE_ALL = 2'd1,
        MOP_PROGRAM   = 2'd2,
        MOP_REPLACE   = 2'd3
    } mem_op_t;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_LOCKED,
        ST_READY,
        ST_BUSY
    } isp_state_t;

    localparam logic [7:0] OPC_ENABLE  = 8'hAC;
    localparam logic [7:0] KEY_ENABLE  = 8'h53;
    localparam logic [7:0] KEY_ERASE   = 8'h80;
    localparam logic [7:0] OPC_RD_PROG = 8'h20;
    localparam logic [7:0] OPC_RD_DATA = 8'hA0;
    localparam logic [7:0] OPC_WR_PROG = 8'h40;
    localparam logic [7:0] OPC_WR_DATA = 8'hC0;
    localparam logic [7:0] OPC_POLL    = 8'hF0;

endpackage

// File: rtl/isp_sck_sync.sv
module isp_sck_sync #(
    parameter int MIN_PHASE = 2,
    parameter int SYNC_LEN  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_n,
    input  logic sck,
    input  logic mosi,
    output logic active,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s,
    output logic phase_err
);
    localparam int CNT_W = $clog2(MIN_PHASE + 2);

    logic [SYNC_LEN-1:0] hold_ff;
    logic [SYNC_LEN:0]   sck_ff;
    logic [SYNC_LEN-1:0] mosi_ff;
    logic [CNT_W-1:0]    phase_cnt;
    logic                phase_seen;
    logic                edge_any;

    // Every input passes through the same depth of flops.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_ff <= '1;
            sck_ff  <= '0;
            mosi_ff <= '0;
        end else begin
            hold_ff <= {hold_ff[SYNC_LEN-2:0], hold_n};
            sck_ff  <= {sck_ff[SYNC_LEN-1:0], sck};
            mosi_ff <= {mosi_ff[SYNC_LEN-2:0], mosi};
        end
    end

    assign active   = ~hold_ff[SYNC_LEN-1];
    assign sck_rise = active &  sck_ff[SYNC_LEN-1] & ~sck_ff[SYNC_LEN];
    assign sck_fall = active & ~sck_ff[SYNC_LEN-1] &  sck_ff[SYNC_LEN];
    assign mosi_s   = mosi_ff[SYNC_LEN-1];
    assign edge_any = sck_rise | sck_fall;

    // Phase width: phase_cnt equals the length of the phase that just ended.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_cnt  <= '0;
            phase_seen <= 1'b0;
            phase_err  <= 1'b0;
        end else if (!active) begin
            phase_cnt  <= '0;
            phase_seen <= 1'b0;
            phase_err  <= 1'b0;
        end else if (edge_any) begin
            if (phase_seen && (int'(phase_cnt) <= MIN_PHASE)) begin
                phase_err <= 1'b1;
            end
            phase_seen <= 1'b1;
            phase_cnt  <= CNT_W'(1);
        end else if (phase_cnt != '1) begin
            phase_cnt <= phase_cnt + CNT_W'(1);
        end
    end

    // R11: once raised, the error stays until the port is released
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_err && active) |=> (phase_err || !active));

endmodule

// File: rtl/isp_shifter.sv
module isp_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       sck_rise,
    input  logic       sck_fall,
    input  logic       mosi_s,
    input  logic       tx_load,
    input  logic [7:0] tx_byte,
    output logic       byte_done,
    output logic [1:0] byte_idx,
    output logic [7:0] rx_byte,
    output logic       miso
);
    logic [4:0] bit_cnt;
    logic [6:0] rx_sh;
    logic [7:0] tx_sh;
    logic       pend;
    logic [7:0] pend_byte;

    // Receive: shift on rising edge, MSB first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            byte_done <= 1'b0;
            byte_idx  <= '0;
            rx_byte   <= '0;
        end else if (!active) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            byte_done <= 1'b0;
            byte_idx  <= '0;
            rx_byte   <= '0;
        end else begin
            byte_done <= 1'b0;
            if (sck_rise) begin
                rx_sh   <= {rx_sh[5:0], mosi_s};
                bit_cnt <= bit_cnt + 5'd1;
                if (bit_cnt[2:0] == 3'd7) begin
                    byte_done <= 1'b1;
                    byte_idx  <= bit_cnt[4:3];
                    rx_byte   <= {rx_sh, mosi_s};
                end
            end
        end
    end

    // Transmit: shift or reload on falling edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh     <= '0;
            pend      <= 1'b0;
            pend_byte <= '0;
        end else if (!active) begin
            tx_sh     <= '0;
            pend      <= 1'b0;
            pend_byte <= '0;
        end else if (tx_load) begin
            if (sck_fall) begin
                tx_sh <= tx_byte;
                pend  <= 1'b0;
            end else begin
                pend      <= 1'b1;
                pend_byte <= tx_byte;
            end
        end else if (sck_fall) begin
            if (pend) begin
                tx_sh <= pend_byte;
                pend  <= 1'b0;
            end else begin
                tx_sh <= {tx_sh[6:0], 1'b0};
            end
        end
    end

    assign miso = tx_sh[7];

    // R4: a completed byte is reported for a single cycle
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);

    // R1: the output is quiet once the port has been released
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !miso);

endmodule

// File: rtl/isp_ctrl.sv
module isp_ctrl
    import isp_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int BUSY_CYC = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              byte_done,
    input  logic [1:0]        byte_idx,
    input  logic [7:0]        rx_byte,
    input  logic [7:0]        mem_rdata,
    output logic              tx_load,
    output logic [7:0]        tx_byte,
    output mem_op_t           mem_op,
    output logic              mem_space,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_re,
    output logic              busy
);
    localparam int BUSY_W = $clog2(BUSY_CYC + 1);

    isp_state_t        state, state_nx;
    logic [7:0]        op_b0, op_b1, addr_lo;
    logic              en_hit, rd_wait;
    logic [BUSY_W-1:0] busy_cnt;
    logic              last_byte, honored, is_read;
    logic [15:0]       addr_full;

    assign last_byte = byte_done && (byte_idx == 2'd3);
    assign honored   = (state == ST_READY) || (state == ST_BUSY);
    assign is_read   = (op_b0 == OPC_RD_PROG) || (op_b0 == OPC_RD_DATA);

    // State register and instruction bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_OFF;
            op_b0    <= '0;
            op_b1    <= '0;
            addr_lo  <= '0;
            en_hit   <= 1'b0;
            rd_wait  <= 1'b0;
            busy_cnt <= '0;
        end else begin
            state   <= state_nx;
            rd_wait <= mem_re;
            if (!active) begin
                op_b0    <= '0;
                op_b1    <= '0;
                addr_lo  <= '0;
                en_hit   <= 1'b0;
                busy_cnt <= '0;
            end else begin
                if (byte_done) begin
                    unique case (byte_idx)
                        2'd0: begin
                            op_b0  <= rx_byte;
                            en_hit <= 1'b0;
                        end
                        2'd1: begin
                            op_b1  <= rx_byte;
                            en_hit <= (op_b0 == OPC_ENABLE) && (rx_byte == KEY_ENABLE);
                        end
                        2'd2: addr_lo <= rx_byte;
                        2'd3: ;
                    endcase
                end
                if (state_nx == ST_BUSY && state != ST_BUSY) begin
                    busy_cnt <= BUSY_W'(BUSY_CYC - 1);
                end else if (state == ST_BUSY && busy_cnt != '0) begin
                    busy_cnt <= busy_cnt - BUSY_W'(1);
                end
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_nx  = state;
        mem_op    = MOP_NONE;
        mem_re    = 1'b0;
        tx_load   = 1'b0;
        tx_byte   = '0;
        addr_full = (byte_idx == 2'd2) ? {op_b1, rx_byte} : {op_b1, addr_lo};
        mem_addr  = addr_full[ADDR_W-1:0];
        mem_space = op_b0[7];
        mem_wdata = rx_byte;

        unique case (state)
            ST_OFF: begin
                if (active) state_nx = ST_LOCKED;
            end
            ST_LOCKED: begin
                if (last_byte && en_hit) state_nx = ST_READY;
            end
            ST_READY: begin
                if (last_byte) begin
                    if (op_b0 == OPC_ENABLE && op_b1 == KEY_ERASE) mem_op = MOP_ERASE_ALL;
                    else if (op_b0 == OPC_WR_PROG)                 mem_op = MOP_PROGRAM;
                    else if (op_b0 == OPC_WR_DATA)                 mem_op = MOP_REPLACE;
                    if (mem_op != MOP_NONE) state_nx = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (busy_cnt == '0) state_nx = ST_READY;
            end
        endcase

        if (byte_done && byte_idx == 2'd1 && op_b0 == OPC_ENABLE && rx_byte == KEY_ENABLE) begin
            tx_load = 1'b1;
            tx_byte = KEY_ENABLE;
        end
        if (honored && byte_done && byte_idx == 2'd2) begin
            if (is_read) begin
                mem_re = 1'b1;
            end else if (op_b0 == OPC_POLL) begin
                tx_load = 1'b1;
                tx_byte = {7'd0, state == ST_BUSY};
            end
        end
        if (rd_wait) begin
            tx_load = 1'b1;
            tx_byte = mem_rdata;
        end

        if (!active) state_nx = ST_OFF;
    end

    assign busy = (state == ST_BUSY);

    assert_locked_no_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKED || state == ST_OFF) |-> (mem_op == MOP_NONE && !mem_re));

    assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mem_op == MOP_NONE));

    assert_busy_after_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_op != MOP_NONE && active) |=> busy);

    assert_release_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (state == ST_OFF));

endmodule

// File: rtl/spi_isp_slave.sv
module spi_isp_slave #(
    parameter int ADDR_W   = 12,
    parameter int BUSY_CYC = 4000,
    parameter bit FAST_CLK = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              miso,
    output logic              sck_err,
    output logic              busy,
    output logic [1:0]        mem_op,
    output logic              mem_space,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata
);
    import isp_pkg::*;

    localparam int MIN_PHASE = FAST_CLK ? 3 : 2;

    logic       active, sck_rise, sck_fall, mosi_s;
    logic       byte_done, tx_load;
    logic [1:0] byte_idx;
    logic [7:0] rx_byte, tx_byte;
    mem_op_t    op_w;

    isp_sck_sync #(.MIN_PHASE(MIN_PHASE), .SYNC_LEN(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .sck(sck), .mosi(mosi),
        .active(active), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .mosi_s(mosi_s), .phase_err(sck_err)
    );

    isp_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .active(active), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .mosi_s(mosi_s), .tx_load(tx_load), .tx_byte(tx_byte),
        .byte_done(byte_done), .byte_idx(byte_idx), .rx_byte(rx_byte), .miso(miso)
    );

    isp_ctrl #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .active(active), .byte_done(byte_done),
        .byte_idx(byte_idx), .rx_byte(rx_byte), .mem_rdata(mem_rdata),
        .tx_load(tx_load), .tx_byte(tx_byte), .mem_op(op_w), .mem_space(mem_space),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_re(mem_re), .busy(busy)
    );

    assign mem_op = op_w;

endmodule

// File: tb/spi_isp_slave_tb.sv
module spi_isp_slave_tb_top;
    localparam int ADDR_W   = 5;
    localparam int BUSY_CYC = 800;
    localparam int HALF     = 5;
    localparam int DEPTH    = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0, hold_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic miso, sck_err, busy, mem_space, mem_re;
    logic [1:0] mem_op;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;

    always #5 clk = ~clk;

    spi_isp_slave #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC), .FAST_CLK(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .sck(sck), .mosi(mosi),
        .miso(miso), .sck_err(sck_err), .busy(busy), .mem_op(mem_op),
        .mem_space(mem_space), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    // Memory model
    logic [7:0] prog_m [DEPTH];
    logic [7:0] data_m [DEPTH];
    int op_cnt = 0;
    logic [1:0] last_op = 2'd0;
    int busy_len = 0;

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            prog_m[i] = 8'(i * 3 + 1);
            data_m[i] = 8'h80 | 8'(i);
        end
        mem_rdata = 8'h00;
    end

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem_space ? data_m[mem_addr] : prog_m[mem_addr];
        case (mem_op)
            2'd1: for (int i = 0; i < DEPTH; i++) begin
                prog_m[i] <= 8'hFF;
                data_m[i] <= 8'hFF;
            end
            2'd2: if (mem_space) data_m[mem_addr] <= data_m[mem_addr] & mem_wdata;
                  else prog_m[mem_addr] <= prog_m[mem_addr] & mem_wdata;
            2'd3: if (mem_space) data_m[mem_addr] <= mem_wdata;
                  else prog_m[mem_addr] <= mem_wdata;
            default: ;
        endcase
        if (mem_op != 2'd0) begin
            op_cnt  <= op_cnt + 1;
            last_op <= mem_op;
            busy_len <= 0;
        end else if (busy) begin
            busy_len <= busy_len + 1;
        end
    end

    // Scoreboard
    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t   exp_q[$];
    logic [7:0] act_q[$];
    int total = 0, bad = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        forever begin
            wait (act_q.size() > 0 && exp_q.size() > 0);
            begin
                sb_item_t   it;
                logic [7:0] a;
                it = exp_q.pop_front();
                a  = act_q.pop_front();
                chk(it.tag, {24'd0, a}, {24'd0, it.exp});
            end
        end
    end

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            mosi = tx[b];
            repeat (HALF) @(negedge clk);
            rx[b] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    // Sends one instruction; byte 3 or byte 4 is scored according to sel.
    task automatic instr(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                         input logic [7:0] b3, input int sel, input logic [7:0] exp,
                         input string tag);
        logic [7:0] r0, r1, r2, r3;
        sb_item_t it;
        if (sel != 0) begin
            it.exp = exp;
            it.tag = tag;
            exp_q.push_back(it);
        end
        xbyte(b0, r0);
        xbyte(b1, r1);
        xbyte(b2, r2);
        xbyte(b3, r3);
        if (sel == 3) act_q.push_back(r2);
        if (sel == 4) act_q.push_back(r3);
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_idle();
        repeat (BUSY_CYC + 10) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset miso", miso, 0);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset mem_op", mem_op, 0);
        chk("R11 reset err", sck_err, 0);

        hold_n = 1'b0;
        repeat (10) @(negedge clk);
        instr(8'h20, 8'h00, 8'h03, 8'h00, 4, 8'h00, "R2 locked read");
        instr(8'h40, 8'h00, 8'h03, 8'h00, 0, 8'h00, "");
        chk("R2 locked write no op", op_cnt, 0);

        instr(8'hAC, 8'h54, 8'h00, 8'h00, 3, 8'h00, "R3 bad key no echo");
        instr(8'hA0, 8'h00, 8'h01, 8'h00, 4, 8'h00, "R3 still locked");
        instr(8'hAC, 8'h53, 8'h00, 8'h00, 3, 8'h53, "R3 enable echo");
        chk("R3 enable no op", op_cnt, 0);

        instr(8'h20, 8'h00, 8'h03, 8'h00, 4, 8'h0A, "R8 read prog (R2 write ignored)");
        instr(8'hA0, 8'h00, 8'h01, 8'h00, 4, 8'h81, "R4 msb first data read");
        instr(8'hA0, 8'hFF, 8'hE4, 8'h00, 4, 8'h84, "R8 address truncated");
        chk("R11 no err on clean phases", sck_err, 0);

        instr(8'hAC, 8'h80, 8'h00, 8'h00, 0, 8'h00, "");
        chk("R5 erase op code", last_op, 1);
        chk("R9 busy after erase", busy, 1);
        instr(8'h40, 8'h00, 8'h05, 8'h00, 0, 8'h00, "");
        chk("R10 write while busy dropped", op_cnt, 1);
        instr(8'hF0, 8'h00, 8'h00, 8'h00, 4, 8'h01, "R9 poll busy");
        wait_idle();
        chk("R9 busy length", busy_len, BUSY_CYC);
        instr(8'hF0, 8'h00, 8'h00, 8'h00, 4, 8'h00, "R9 poll idle");
        instr(8'h20, 8'h00, 8'h05, 8'h00, 4, 8'hFF, "R5 R10 prog erased");
        instr(8'hA0, 8'h00, 8'h07, 8'h00, 4, 8'hFF, "R5 data erased");

        instr(8'h40, 8'h00, 8'h05, 8'h3C, 0, 8'h00, "");
        chk("R7 program op code", last_op, 2);
        wait_idle();
        instr(8'h20, 8'h00, 8'h05, 8'h00, 4, 8'h3C, "R7 program write");
        instr(8'h40, 8'h00, 8'h05, 8'hF0, 0, 8'h00, "");
        wait_idle();
        instr(8'h20, 8'h00, 8'h05, 8'h00, 4, 8'h30, "R7 program clears only");

        instr(8'hC0, 8'h00, 8'h07, 8'h3C, 0, 8'h00, "");
        chk("R6 replace op code", last_op, 3);
        wait_idle();
        instr(8'hA0, 8'h00, 8'h07, 8'h00, 4, 8'h3C, "R6 data write");
        instr(8'hC0, 8'h00, 8'h07, 8'hC3, 0, 8'h00, "");
        wait_idle();
        instr(8'hA0, 8'h00, 8'h07, 8'h00, 4, 8'hC3, "R6 auto erase");

        begin
            logic [7:0] dummy;
            xbyte(8'hAC, dummy);
            xbyte(8'h53, dummy);
        end
        hold_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R1 release miso", miso, 0);
        chk("R1 release busy", busy, 0);
        hold_n = 1'b0;
        repeat (10) @(negedge clk);
        instr(8'h20, 8'h00, 8'h05, 8'h00, 4, 8'h00, "R1 relocked after abort");

        sck = 1'b1;
        repeat (2) @(negedge clk);
        sck = 1'b0;
        repeat (8) @(negedge clk);
        chk("R11 short phase flagged", sck_err, 1);
        hold_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R11 flag cleared on release", sck_err, 0);

        wait (exp_q.size() == 0);
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule